// File: doc/BRIEF.md
# Paired Debug Trigger Fire Unit

This block holds ten hardware debug triggers, organised as five fixed pairs, and decides on every retiring instruction whether a debug trap must be raised. Each trigger watches one kind of address (the instruction fetch address, a load address or a store address) and compares it with a programmed value under one of four compare modes. Software-style configuration writes arrive through a single write port that carries a trigger index and all of that trigger's fields at once.

Inside a pair the two triggers may be linked, so that the pair only fires when both of its triggers match the same instruction with the same timing. A timing bit on each trigger chooses between trapping on the matching instruction itself and trapping on the next instruction that retires. A deferred trap is held in a pending flag until the next valid instruction, or until a flush drops it. The outputs are a fire-now pulse, a fire-next pulse and the index of the trigger that caused the reported trap.

Top module: `dbg_trig_fire`

## Requirements
- R1: After reset every trigger is disabled: no retiring instruction raises `fire_now` or `fire_next`, and `fire_idx` reads 0.
- R2: `cfg_mode` selects the compare: 0 = address equals value; 1 = aligned range, where the value's trailing one bits plus one more bit are don't-care; 2 = address greater than or equal to value (unsigned); 3 = address less than value (unsigned).
- R3: Pair p (triggers 2p, 2p+1) watches, in that order: pair 0 fetch/fetch, pair 1 store/store, pair 2 load/load, pair 3 fetch/store, pair 4 fetch/load. Fetch triggers compare `ret_pc` on every valid instruction; load triggers compare `ret_maddr` only when `ret_load` is 1; store triggers compare `ret_maddr` only when `ret_store` is 1. No data value is compared.
- R4: A trigger whose enable is 0 never matches and never completes a linked pair.
- R5: The link bit written to the even trigger 2p links pair p; a linked pair fires only when both its triggers match in the same cycle, and then both fire. A link bit written to an odd trigger is ignored.
- R6: In a linked pair whose two triggers have different timing bits, neither fires even when both match.
- R7: A link request on the store/store pair (pair 1) is ignored; its triggers always fire independently.
- R8: A firing trigger with timing 0 raises `fire_now` combinationally in the same cycle as the matching `ret_valid`.
- R9: A firing trigger with timing 1 sets a pending flag; `fire_next` is raised on the next cycle with `ret_valid` = 1 (cycles without a valid instruction keep it waiting) and the flag then clears.
- R10: `flush` clears the pending flag without raising `fire_next`.
- R11: A configuration write takes effect from the cycle after the clock edge that captures `cfg_we`; an instruction retiring in the write cycle sees the old settings. Writes with `cfg_idx` of 10 or more change nothing.
- R12: `fire_idx` reports the lowest-numbered firing trigger; a current-instruction trap takes priority over a pending deferred trap, which is then dropped; `fire_now` and `fire_next` are never high together, and `fire_idx` is 0 when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Index of the trigger being written |
| cfg_en | input | 1 | Trigger enable |
| cfg_mode | input | 2 | Compare mode (R2) |
| cfg_value | input | 32 | Compare value |
| cfg_timing | input | 1 | 0 = trap this instruction, 1 = trap next instruction |
| cfg_chain | input | 1 | Link request for the pair (even trigger only) |
| ret_valid | input | 1 | A retiring instruction is present |
| ret_pc | input | 32 | Fetch address of the retiring instruction |
| ret_maddr | input | 32 | Memory address of the retiring instruction |
| ret_load | input | 1 | Retiring instruction is a load |
| ret_store | input | 1 | Retiring instruction is a store |
| flush | input | 1 | Drops a pending deferred trap |
| fire_now | output | 1 | Trap on the current instruction |
| fire_next | output | 1 | Deferred trap delivered on this instruction |
| fire_idx | output | 4 | Index of the trigger behind the reported trap |

## Verification
The hardest situation to reach is the collision between a pending deferred trap and a fresh current-instruction hit, because it needs one trigger armed with timing 1, a retirement that matches it, and a second trigger with timing 0 that matches the very next valid instruction. The bench programs trigger 0 for deferral and trigger 6 for an immediate trap on a different address, retires the two addresses back to back, then retires a neutral address to show the deferred trap was dropped. Linked-pair corners are reached the same way: a disabled partner, a partner with a mismatched address and a partner with different timing are each set up through the write port before one retirement.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STORE = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        CMP_EQ    = 2'd0,
        CMP_RANGE = 2'd1,
        CMP_GE    = 2'd2,
        CMP_LT    = 2'd3
    } cmp_e;

    // Fixed kind of each pair member; the pattern repeats every five pairs.
    function automatic src_e pair_src(input int pair, input bit upper);
        case (pair % 5)
            0:       return SRC_FETCH;
            1:       return SRC_STORE;
            2:       return SRC_LOAD;
            3:       return upper ? SRC_STORE : SRC_FETCH;
            default: return upper ? SRC_LOAD : SRC_FETCH;
        endcase
    endfunction

    // Only the even member of a pair that is not store/store keeps a link bit.
    function automatic bit link_kept(input int trig);
        return ((trig % 2) == 0) && (((trig / 2) % 5) != 1);
    endfunction

endpackage

// File: rtl/trig_slot.sv
module trig_slot
    import dbg_trig_pkg::*;
#(
    parameter int   ID      = 0,
    parameter int   ADDR_W  = 32,
    parameter int   IDX_W   = 4,
    parameter src_e KIND    = SRC_FETCH,
    parameter bit   LINK_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] value,
    input  logic              timing,
    input  logic              chain,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] ret_maddr,
    input  logic              ret_load,
    input  logic              ret_store,
    output logic              hit,
    output logic              tim,
    output logic              lnk
);

    typedef struct packed {
        logic              en;
        logic [1:0]        mode;
        logic [ADDR_W-1:0] val;
        logic              tim;
        logic              lnk;
    } slot_cfg_t;

    slot_cfg_t cfg_d, cfg_q;
    logic [ADDR_W-1:0] addr, dontcare;
    logic kind_ok, cmp_ok;
    logic sel;

    assign sel = we && (idx == IDX_W'(ID));

    always_comb begin
        cfg_d = cfg_q;
        if (sel) begin
            cfg_d.en   = en;
            cfg_d.mode = mode;
            cfg_d.val  = value;
            cfg_d.tim  = timing;
            cfg_d.lnk  = LINK_OK ? chain : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        addr     = (KIND == SRC_FETCH) ? ret_pc : ret_maddr;
        kind_ok  = (KIND == SRC_FETCH) ? 1'b1 :
                   (KIND == SRC_LOAD)  ? ret_load : ret_store;
        dontcare = cfg_q.val ^ (cfg_q.val + 1'b1);
        case (cmp_e'(cfg_q.mode))
            CMP_EQ:    cmp_ok = (addr == cfg_q.val);
            CMP_RANGE: cmp_ok = ((addr ^ cfg_q.val) & ~dontcare) == '0;
            CMP_GE:    cmp_ok = (addr >= cfg_q.val);
            default:   cmp_ok = (addr <  cfg_q.val);
        endcase
        hit = cfg_q.en && kind_ok && cmp_ok;
    end

    assign tim = cfg_q.tim;
    assign lnk = cfg_q.lnk;

    // R11: settings only move on a write addressed to this trigger
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(tim) && $stable(lnk)));

endmodule

// File: rtl/trig_pair.sv
module trig_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_a,
    input  logic hit_b,
    input  logic tim_a,
    input  logic tim_b,
    input  logic linked,
    output logic fire_a,
    output logic fire_b
);

    logic both;

    always_comb begin
        both = hit_a && hit_b && (tim_a == tim_b);
        if (linked) begin
            fire_a = both;
            fire_b = both;
        end else begin
            fire_a = hit_a;
            fire_b = hit_b;
        end
    end

    // R5: a linked pair fires as a unit and only with both members matching
    assert_link_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        linked |-> ((fire_a == fire_b) && (!fire_a || (hit_a && hit_b))));

    // R6: differing timing inside a linked pair blocks the pair
    assert_link_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && (tim_a != tim_b)) |-> (!fire_a && !fire_b));

endmodule

// File: rtl/dbg_trig_fire.sv
module dbg_trig_fire
    import dbg_trig_pkg::*;
#(
    parameter int NUM_PAIRS = 5,
    parameter int ADDR_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [$clog2(2*NUM_PAIRS)-1:0]   cfg_idx,
    input  logic                             cfg_en,
    input  logic [1:0]                       cfg_mode,
    input  logic [ADDR_W-1:0]                cfg_value,
    input  logic                             cfg_timing,
    input  logic                             cfg_chain,
    input  logic                             ret_valid,
    input  logic [ADDR_W-1:0]                ret_pc,
    input  logic [ADDR_W-1:0]                ret_maddr,
    input  logic                             ret_load,
    input  logic                             ret_store,
    input  logic                             flush,
    output logic                             fire_now,
    output logic                             fire_next,
    output logic [$clog2(2*NUM_PAIRS)-1:0]   fire_idx
);

    localparam int NUM_TRIG = 2 * NUM_PAIRS;
    localparam int IDX_W    = $clog2(NUM_TRIG);

    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] pend_idx;
    } defer_t;

    logic [NUM_TRIG-1:0] hit, tim, lnk, fire;

    genvar p;
    generate
        for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
            for (genvar m = 0; m < 2; m++) begin : g_slot
                trig_slot #(
                    .ID(2*p + m), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
                    .KIND(pair_src(p, m != 0)), .LINK_OK(link_kept(2*p + m))
                ) u_slot (
                    .clk(clk), .rst_n(rst_n),
                    .we(cfg_we), .idx(cfg_idx), .en(cfg_en), .mode(cfg_mode),
                    .value(cfg_value), .timing(cfg_timing), .chain(cfg_chain),
                    .ret_pc(ret_pc), .ret_maddr(ret_maddr),
                    .ret_load(ret_load), .ret_store(ret_store),
                    .hit(hit[2*p+m]), .tim(tim[2*p+m]), .lnk(lnk[2*p+m])
                );
            end

            trig_pair u_pair (
                .clk(clk), .rst_n(rst_n),
                .hit_a(hit[2*p]), .hit_b(hit[2*p+1]),
                .tim_a(tim[2*p]), .tim_b(tim[2*p+1]),
                .linked(lnk[2*p] | lnk[2*p+1]),
                .fire_a(fire[2*p]), .fire_b(fire[2*p+1])
            );

            if ((p % 5) == 1) begin : g_store_pair
                // R7: store/store members always act on their own match
                assert_store_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (fire[2*p] == hit[2*p]) && (fire[2*p+1] == hit[2*p+1]));
            end
        end
    endgenerate

    defer_t st_d, st_q;
    logic             now_any, later_any;
    logic [IDX_W-1:0] now_idx, later_idx;

    always_comb begin
        now_any   = 1'b0;
        later_any = 1'b0;
        now_idx   = '0;
        later_idx = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (ret_valid && fire[i] && !tim[i]) begin
                now_any = 1'b1;
                now_idx = IDX_W'(i);
            end
            if (ret_valid && fire[i] && tim[i]) begin
                later_any = 1'b1;
                later_idx = IDX_W'(i);
            end
        end

        fire_now  = now_any;
        fire_next = ret_valid && st_q.pend && !now_any;
        if (now_any)        fire_idx = now_idx;
        else if (fire_next) fire_idx = st_q.pend_idx;
        else                fire_idx = '0;

        st_d = st_q;
        if (ret_valid) st_d.pend = 1'b0;
        if (later_any) begin
            st_d.pend     = 1'b1;
            st_d.pend_idx = later_idx;
        end
        if (flush) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: at most one kind of trap reported per instruction
    assert_one_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_now && fire_next));

    // R12: the reported index names an existing trigger
    assert_idx_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fire_idx < IDX_W'(NUM_TRIG));

    // R8: immediate traps only accompany a retiring instruction
    assert_now_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_now |-> ret_valid);

    // R9: a deferred trap is delivered once
    assert_next_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_next && !later_any) |=> !fire_next);

    // R10: a flush leaves nothing to deliver
    assert_flush_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fire_next);

endmodule

// File: tb/dbg_trig_fire_test.sv
module dbg_trig_fire_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [31:0] cfg_value = '0;
    logic        cfg_timing = 1'b0;
    logic        cfg_chain = 1'b0;
    logic        ret_valid = 1'b0;
    logic [31:0] ret_pc = '0;
    logic [31:0] ret_maddr = '0;
    logic        ret_load = 1'b0;
    logic        ret_store = 1'b0;
    logic        flush = 1'b0;
    logic        fire_now, fire_next;
    logic [3:0]  fire_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_trig_fire uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_value(cfg_value), .cfg_timing(cfg_timing), .cfg_chain(cfg_chain),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_maddr(ret_maddr),
        .ret_load(ret_load), .ret_store(ret_store), .flush(flush),
        .fire_now(fire_now), .fire_next(fire_next), .fire_idx(fire_idx)
    );

    // mode[66:65] value[64:33] pc[32:1] expected_fire[0]
    localparam logic [66:0] VECS [0:10] = '{
        {2'd0, 32'h0000_1234, 32'h0000_1234, 1'b1},
        {2'd0, 32'h0000_1234, 32'h0000_1235, 1'b0},
        {2'd1, 32'h0000_1007, 32'h0000_100F, 1'b1},
        {2'd1, 32'h0000_1007, 32'h0000_1010, 1'b0},
        {2'd1, 32'h0000_2000, 32'h0000_2001, 1'b1},
        {2'd1, 32'h0000_2000, 32'h0000_2002, 1'b0},
        {2'd2, 32'h0000_0800, 32'h0000_0800, 1'b1},
        {2'd2, 32'h0000_0800, 32'h0000_07FF, 1'b0},
        {2'd3, 32'h0000_0800, 32'h0000_07FF, 1'b1},
        {2'd3, 32'h0000_0800, 32'h0000_0800, 1'b0},
        {2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input bit en, input logic [1:0] mode,
                             input logic [31:0] val, input bit tmg, input bit lnk);
        @(negedge clk);
        ret_valid  = 1'b0;
        cfg_we     = 1'b1;
        cfg_idx    = 4'(idx);
        cfg_en     = en;
        cfg_mode   = mode;
        cfg_value  = val;
        cfg_timing = tmg;
        cfg_chain  = lnk;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic retire(input logic [31:0] pc, input logic [31:0] ma, input bit ld, input bit stv);
        @(negedge clk);
        ret_valid = 1'b1;
        ret_pc    = pc;
        ret_maddr = ma;
        ret_load  = ld;
        ret_store = stv;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        ret_valid = 1'b0;
        #1;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 10; i++) cfg_write(i, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, value 0 mode equal would match pc 0 if enabled
        retire(32'h0, 32'h0, 1'b1, 1'b0);
        chk("R1 fire_now", fire_now, 0);
        chk("R1 fire_next", fire_next, 0);
        chk("R1 fire_idx", fire_idx, 0);

        // R2: compare modes from the vector table on fetch trigger 0
        foreach (VECS[k]) begin
            cfg_write(0, 1'b1, VECS[k][66:65], VECS[k][64:33], 1'b0, 1'b0);
            retire(VECS[k][32:1], 32'h0, 1'b0, 1'b0);
            chk($sformatf("R2 vector %0d", k), fire_now, VECS[k][0]);
        end
        clear_all();

        // R3: store trigger 2 ignores a load, fires on a store
        cfg_write(2, 1'b1, 2'd0, 32'h100, 1'b0, 1'b0);
        retire(32'h0, 32'h100, 1'b1, 1'b0);
        chk("R3 store trig on load", fire_now, 0);
        retire(32'h0, 32'h100, 1'b0, 1'b1);
        chk("R3 store trig on store", fire_now, 1);
        chk("R3 store trig idx", fire_idx, 2);
        // R3: load trigger 4 fires on a load; fetch trigger 6 on pc; store trigger 7
        cfg_write(4, 1'b1, 2'd0, 32'h140, 1'b0, 1'b0);
        retire(32'h140, 32'h0, 1'b1, 1'b0);
        chk("R3 load trig on pc only", fire_now, 0);
        retire(32'h0, 32'h140, 1'b1, 1'b0);
        chk("R3 load trig idx", fire_idx, 4);
        cfg_write(6, 1'b1, 2'd0, 32'h180, 1'b0, 1'b0);
        cfg_write(7, 1'b1, 2'd0, 32'h1C0, 1'b0, 1'b0);
        retire(32'h180, 32'h0, 1'b0, 1'b0);
        chk("R3 fetch trig idx", fire_idx, 6);
        retire(32'h0, 32'h1C0, 1'b0, 1'b1);
        chk("R3 pair3 store member idx", fire_idx, 7);
        clear_all();

        // R4: linked pair 0 with a disabled partner
        cfg_write(0, 1'b1, 2'd0, 32'h40, 1'b0, 1'b1);
        cfg_write(1, 1'b0, 2'd0, 32'h40, 1'b0, 1'b0);
        retire(32'h40, 32'h0, 1'b0, 1'b0);
        chk("R4 disabled partner blocks", fire_now, 0);
        // R5: both match -> fires, lowest index
        cfg_write(1, 1'b1, 2'd0, 32'h40, 1'b0, 1'b0);
        retire(32'h40, 32'h0, 1'b0, 1'b0);
        chk("R5 linked both match", fire_now, 1);
        chk("R5 linked idx", fire_idx, 0);
        cfg_write(1, 1'b1, 2'd0, 32'h44, 1'b0, 1'b0);
        retire(32'h40, 32'h0, 1'b0, 1'b0);
        chk("R5 linked one match", fire_now, 0);
        // R6: both match, different timing
        cfg_write(1, 1'b1, 2'd0, 32'h40, 1'b1, 1'b0);
        retire(32'h40, 32'h0, 1'b0, 1'b0);
        chk("R6 timing mismatch now", fire_now, 0);
        retire(32'h0, 32'h0, 1'b0, 1'b0);
        chk("R6 timing mismatch next", fire_next, 0);
        clear_all();

        // R7: link request on store/store pair ignored
        cfg_write(2, 1'b1, 2'd0, 32'h200, 1'b0, 1'b1);
        cfg_write(3, 1'b1, 2'd0, 32'h300, 1'b0, 1'b0);
        retire(32'h0, 32'h200, 1'b0, 1'b1);
        chk("R7 store pair unlinked", fire_now, 1);
        chk("R7 store pair idx", fire_idx, 2);
        clear_all();

        // R5: link bit written to odd trigger 9 is ignored
        cfg_write(8, 1'b1, 2'd0, 32'h80, 1'b0, 1'b0);
        cfg_write(9, 1'b1, 2'd0, 32'h90, 1'b0, 1'b1);
        retire(32'h80, 32'h0, 1'b0, 1'b0);
        chk("R5 odd link ignored", fire_now, 1);
        chk("R5 odd link idx", fire_idx, 8);
        clear_all();

        // R8 / R9: timing 1 defers to next valid instruction
        cfg_write(0, 1'b1, 2'd0, 32'h10, 1'b1, 1'b0);
        retire(32'h10, 32'h0, 1'b0, 1'b0);
        chk("R8 deferred no now", fire_now, 0);
        chk("R9 deferred not same cycle", fire_next, 0);
        idle();
        chk("R9 idle no fire_next", fire_next, 0);
        retire(32'h20, 32'h0, 1'b0, 1'b0);
        chk("R9 fire_next delivered", fire_next, 1);
        chk("R9 fire_next idx", fire_idx, 0);
        retire(32'h20, 32'h0, 1'b0, 1'b0);
        chk("R9 fire_next cleared", fire_next, 0);

        // R10: flush drops pending
        retire(32'h10, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        ret_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        retire(32'h20, 32'h0, 1'b0, 1'b0);
        chk("R10 flush drops pending", fire_next, 0);

        // R12: immediate trap beats pending, pending dropped
        cfg_write(6, 1'b1, 2'd0, 32'h70, 1'b0, 1'b0);
        retire(32'h10, 32'h0, 1'b0, 1'b0);
        retire(32'h70, 32'h0, 1'b0, 1'b0);
        chk("R12 now wins", fire_now, 1);
        chk("R12 next suppressed", fire_next, 0);
        chk("R12 now idx", fire_idx, 6);
        retire(32'h0, 32'h0, 1'b0, 1'b0);
        chk("R12 pending dropped", fire_next, 0);
        clear_all();

        // R12: lowest of two simultaneous fires
        cfg_write(5, 1'b1, 2'd0, 32'h60, 1'b0, 1'b0);
        cfg_write(4, 1'b1, 2'd0, 32'h60, 1'b0, 1'b0);
        retire(32'h0, 32'h60, 1'b1, 1'b0);
        chk("R12 lowest idx", fire_idx, 4);
        clear_all();

        // R11: write and retire in the same cycle sees old settings
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd0; cfg_en = 1'b1; cfg_mode = 2'd0;
        cfg_value = 32'h30; cfg_timing = 1'b0; cfg_chain = 1'b0;
        ret_valid = 1'b1; ret_pc = 32'h30; ret_load = 1'b0; ret_store = 1'b0;
        #1;
        chk("R11 write cycle old cfg", fire_now, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R11 next cycle new cfg", fire_now, 1);
        // R11: out-of-range index changes nothing
        cfg_write(12, 1'b1, 2'd0, 32'h50, 1'b0, 1'b0);
        retire(32'h50, 32'h50, 1'b1, 1'b1);
        chk("R11 idx 12 ignored", fire_now, 0);
        retire(32'h30, 32'h0, 1'b0, 1'b0);
        chk("R11 trig0 unchanged", fire_now, 1);
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule